// File: doc/BRIEF.md
# Flow-Control Transmit Gate

This block holds back the start of Ethernet frame transmissions while a flow-control pause from the link partner is in force. It only acts in full-duplex operation with flow control enabled. A strobe from the frame receiver delivers the quanta value of each validated pause frame. That value loads a countdown timer. The timer steps down once per quanta tick, and each tick marks one 512-bit-time interval.

Software requests a transmission by pulsing a set strobe for the request bit. If no pause is running, the frame is launched at once. If a pause is running, the request is kept pending and is launched automatically on the cycle after the timer reaches zero. A request is neither refused nor started early. When the MAC reports the end of the frame, the request bit clears and a one-cycle completion interrupt fires. A pause that arrives during a transmission never cuts that frame short. It only holds back later launches.

Top module: `pause_tx_inhibit`

## Requirements
- R1: After a synchronous reset, tx_start, tx_irq, tx_pending, tx_active and pause_active are all 0.
- R2: With no pause running, a tx_req_set sampled at edge N sets tx_pending after edge N. tx_start is then high for exactly one cycle after edge N+1, and tx_active rises at the same edge.
- R3: With full_duplex=1 and fc_enable=1, a pause_valid strobe that carries a nonzero pause_quanta sets pause_active after the same edge.
- R4: The timer decreases by one on each edge where quanta_tick=1, and holds its value otherwise. A load of Q therefore ends the pause (pause_active=0) after the Q-th tick.
- R5: With full_duplex=0 or fc_enable=0, pause_valid is ignored. Dropping either input while a pause runs clears the timer, so pause_active=0 after that edge.
- R6: A request made while pause_active=1 stays pending (tx_pending=1), and tx_start stays 0 for as long as the pause lasts.
- R7: A pending request is launched with no further software action. tx_start pulses after the edge that follows the edge at which the pause ended.
- R8: A new pause_valid while the timer runs reloads it with the new value. A value of 0 ends the pause at that edge.
- R9: A pause that arrives while tx_active=1 leaves that transmission running. Its tx_done still completes it normally.
- R10: tx_done while tx_active=1 clears tx_pending and tx_active and pulses tx_irq for one cycle after that edge. tx_done with no transmission running has no effect.
- R11: Each request yields exactly one tx_start. A tx_req_set while a request is pending or in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| full_duplex | input | 1 | 1 = full-duplex link |
| fc_enable | input | 1 | 1 = honour received pause frames |
| pause_valid | input | 1 | Strobe: a validated pause frame arrived |
| pause_quanta | input | QUANTA_W | Pause length in quanta, sampled with pause_valid |
| quanta_tick | input | 1 | One pulse per 512-bit-time interval |
| tx_req_set | input | 1 | Software strobe that sets the request bit |
| tx_done | input | 1 | MAC reports end of the current frame |
| tx_start | output | 1 | One-cycle launch strobe to the MAC |
| tx_pending | output | 1 | Request bit (pending or in flight) |
| tx_active | output | 1 | A launched frame is in flight |
| pause_active | output | 1 | Transmit launches are currently inhibited |
| tx_irq | output | 1 | One-cycle transmit-complete interrupt |

## Verification
The launch path is exercised with a request under each pause condition: no pause, a running pause, a pause that expires through ticks, and a pause cut short by a zero reload. These cases show whether the hold is keyed to the timer and whether the automatic launch lands exactly one cycle after expiry. Pause frames are also sent in half duplex, with flow control off, and while a frame is in flight. Those runs show whether the gate wrongly engages or wrongly aborts a frame. Reload sequences and stray done or request strobes show whether the timer restarts from the new value and whether extra strobes create extra launches or interrupts.

// File: rtl/pause_gate_pkg.sv
package pause_gate_pkg;

    localparam int DEF_QUANTA_W = 16;

    typedef enum logic [1:0] {
        TXS_IDLE = 2'd0,
        TXS_HELD = 2'd1,
        TXS_SEND = 2'd2
    } tx_state_e;

    // Flow control applies only to a full-duplex link with the feature on
    function automatic logic fc_applies(input logic duplex, input logic fc_on);
        return duplex & fc_on;
    endfunction

endpackage

// File: rtl/pause_countdown.sv
module pause_countdown #(
    parameter int QUANTA_W = pause_gate_pkg::DEF_QUANTA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                load,
    input  logic [QUANTA_W-1:0] load_val,
    input  logic                tick,
    output logic                running
);
    typedef logic [QUANTA_W-1:0] quanta_t;
    localparam quanta_t ZERO = '0;

    quanta_t count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= ZERO;
        end else if (!enable) begin
            count <= ZERO;
        end else if (load) begin
            count <= load_val;
        end else if (tick && count != ZERO) begin
            count <= count - quanta_t'(1);
        end
    end

    assign running = (count != ZERO);

    // R4
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && !load && !tick) |=> (count == $past(count)));

    // R8
    zero_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && load && load_val == ZERO) |=> !running);

    // R5
    disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !running);

endmodule

// File: rtl/tx_launch_ctrl.sv
module tx_launch_ctrl
    import pause_gate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic inhibit,
    input  logic req_set,
    input  logic done,
    output logic start,
    output logic pending,
    output logic active,
    output logic irq
);
    tx_state_e state, state_nx;
    logic      launch;

    always_comb begin
        state_nx = state;
        launch   = 1'b0;
        unique case (state)
            TXS_IDLE: if (req_set) state_nx = TXS_HELD;
            TXS_HELD: if (!inhibit) begin
                state_nx = TXS_SEND;
                launch   = 1'b1;
            end
            TXS_SEND: if (done) state_nx = TXS_IDLE;
            default:  state_nx = TXS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TXS_IDLE;
            start <= 1'b0;
            irq   <= 1'b0;
        end else begin
            state <= state_nx;
            start <= launch;
            irq   <= (state == TXS_SEND) && done;
        end
    end

    assign pending = (state != TXS_IDLE);
    assign active  = (state == TXS_SEND);

    // R6
    held_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == TXS_HELD && inhibit) |=> !start);

    // R11
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

    // R10
    irq_after_end_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> !active);

    // R9
    send_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !done) |=> active);

endmodule

// File: rtl/pause_tx_inhibit.sv
module pause_tx_inhibit
    import pause_gate_pkg::*;
#(
    parameter int QUANTA_W = DEF_QUANTA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                full_duplex,
    input  logic                fc_enable,
    input  logic                pause_valid,
    input  logic [QUANTA_W-1:0] pause_quanta,
    input  logic                quanta_tick,
    input  logic                tx_req_set,
    input  logic                tx_done,
    output logic                tx_start,
    output logic                tx_pending,
    output logic                tx_active,
    output logic                pause_active,
    output logic                tx_irq
);
    logic gate_on;
    logic timer_running;

    assign gate_on = fc_applies(full_duplex, fc_enable);

    pause_countdown #(.QUANTA_W(QUANTA_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .enable   (gate_on),
        .load     (pause_valid),
        .load_val (pause_quanta),
        .tick     (quanta_tick),
        .running  (timer_running)
    );

    assign pause_active = timer_running;

    tx_launch_ctrl u_launch (
        .clk     (clk),
        .rst     (rst),
        .inhibit (timer_running),
        .req_set (tx_req_set),
        .done    (tx_done),
        .start   (tx_start),
        .pending (tx_pending),
        .active  (tx_active),
        .irq     (tx_irq)
    );

    // R3
    pause_engage_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_on && pause_valid && pause_quanta != '0) |=> pause_active);

    // R2
    start_sets_active_chk: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> tx_active);

endmodule

// File: tb/test_pause_tx_inhibit.sv
module test_pause_tx_inhibit;
    localparam int QW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          full_duplex = 1'b1, fc_enable = 1'b1;
    logic          pause_valid = 1'b0, quanta_tick = 1'b0;
    logic [QW-1:0] pause_quanta = '0;
    logic          tx_req_set = 1'b0, tx_done = 1'b0;
    logic          tx_start, tx_pending, tx_active, pause_active, tx_irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    pause_tx_inhibit #(.QUANTA_W(QW)) i_pause_tx_inhibit (
        .clk(clk), .rst(rst), .full_duplex(full_duplex), .fc_enable(fc_enable),
        .pause_valid(pause_valid), .pause_quanta(pause_quanta),
        .quanta_tick(quanta_tick), .tx_req_set(tx_req_set), .tx_done(tx_done),
        .tx_start(tx_start), .tx_pending(tx_pending), .tx_active(tx_active),
        .pause_active(pause_active), .tx_irq(tx_irq)
    );

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic pulse_req();
        tx_req_set = 1'b1; cyc(); tx_req_set = 1'b0;
    endtask

    task automatic pulse_done();
        tx_done = 1'b1; cyc(); tx_done = 1'b0;
    endtask

    task automatic pulse_pause(input logic [QW-1:0] q);
        pause_quanta = q; pause_valid = 1'b1; cyc(); pause_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        quanta_tick = 1'b1; cyc(n); quanta_tick = 1'b0;
    endtask

    task automatic test_reset();
        rst = 1'b1; cyc(2); rst = 1'b0;
        chk("R1", "tx_start", tx_start, 1'b0);
        chk("R1", "tx_irq", tx_irq, 1'b0);
        chk("R1", "tx_pending", tx_pending, 1'b0);
        chk("R1", "tx_active", tx_active, 1'b0);
        chk("R1", "pause_active", pause_active, 1'b0);
    endtask

    task automatic test_plain_send();
        pulse_req();
        chk("R2", "pending after req", tx_pending, 1'b1);
        chk("R2", "no start yet", tx_start, 1'b0);
        cyc();
        chk("R2", "start pulse", tx_start, 1'b1);
        chk("R2", "active", tx_active, 1'b1);
        tx_req_set = 1'b1; cyc(); tx_req_set = 1'b0;
        chk("R11", "start single", tx_start, 1'b0);
        cyc(2);
        chk("R11", "no second start", tx_start, 1'b0);
        pulse_done();
        chk("R10", "irq", tx_irq, 1'b1);
        chk("R10", "pending cleared", tx_pending, 1'b0);
        chk("R10", "active cleared", tx_active, 1'b0);
        cyc();
        chk("R10", "irq one cycle", tx_irq, 1'b0);
        chk("R11", "ignored req left nothing", tx_pending, 1'b0);
    endtask

    task automatic test_stray_done();
        pulse_done();
        chk("R10", "no irq when idle", tx_irq, 1'b0);
        chk("R10", "still idle", tx_pending, 1'b0);
    endtask

    task automatic test_held_then_expire();
        pulse_pause(16'd3);
        chk("R3", "pause engaged", pause_active, 1'b1);
        pulse_req();
        chk("R6", "held pending", tx_pending, 1'b1);
        cyc(3);
        chk("R6", "no start in pause", tx_start, 1'b0);
        chk("R4", "no tick keeps pause", pause_active, 1'b1);
        ticks(2);
        chk("R4", "active after 2 of 3", pause_active, 1'b1);
        chk("R6", "no start after 2", tx_start, 1'b0);
        ticks(1);
        chk("R4", "expired after 3", pause_active, 1'b0);
        chk("R7", "no start at expiry edge", tx_start, 1'b0);
        cyc();
        chk("R7", "auto launch", tx_start, 1'b1);
        chk("R7", "active", tx_active, 1'b1);
        pulse_done();
        chk("R7", "completion irq", tx_irq, 1'b1);
        cyc();
    endtask

    task automatic test_reload();
        pulse_pause(16'd2);
        ticks(1);
        pulse_pause(16'd4);
        ticks(3);
        chk("R8", "reloaded still active", pause_active, 1'b1);
        ticks(1);
        chk("R8", "ends after new value", pause_active, 1'b0);
        pulse_pause(16'd9);
        pulse_req();
        chk("R8", "held before zero", tx_start, 1'b0);
        pulse_pause(16'd0);
        chk("R8", "zero ends pause", pause_active, 1'b0);
        cyc();
        chk("R8", "launch after zero", tx_start, 1'b1);
        pulse_done();
        cyc();
    endtask

    task automatic test_pause_in_flight();
        pulse_req(); cyc();
        chk("R9", "launched", tx_start, 1'b1);
        pulse_pause(16'd5);
        chk("R9", "pause on", pause_active, 1'b1);
        chk("R9", "frame kept", tx_active, 1'b1);
        cyc(2);
        chk("R9", "still in flight", tx_active, 1'b1);
        pulse_done();
        chk("R9", "done completes", tx_irq, 1'b1);
        pulse_req(); cyc();
        chk("R9", "later start delayed", tx_start, 1'b0);
        ticks(5);
        cyc();
        chk("R9", "later start after pause", tx_start, 1'b1);
        pulse_done();
        cyc();
    endtask

    task automatic test_gating();
        full_duplex = 1'b0;
        pulse_pause(16'd7);
        chk("R5", "half duplex ignores", pause_active, 1'b0);
        pulse_req(); cyc();
        chk("R5", "half duplex sends", tx_start, 1'b1);
        pulse_done();
        full_duplex = 1'b1; fc_enable = 1'b0;
        pulse_pause(16'd7);
        chk("R5", "fc off ignores", pause_active, 1'b0);
        fc_enable = 1'b1;
        pulse_pause(16'd7);
        chk("R5", "pause on again", pause_active, 1'b1);
        fc_enable = 1'b0; cyc();
        chk("R5", "fc drop clears", pause_active, 1'b0);
        fc_enable = 1'b1; cyc();
        chk("R5", "timer cleared not resumed", pause_active, 1'b0);
        full_duplex = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_plain_send();
        test_stray_done();
        test_held_then_expire();
        test_reload();
        test_pause_in_flight();
        test_gating();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule